// File: doc/BRIEF.md
# SPI Pause (Hold) Qualifier

This unit sits between the synchronized serial pins and the command engine of a serial memory slave. It decides, cycle by cycle in the system-clock domain, whether the serial clock edges seen on the bus should reach the engine or be swallowed because the host has paused the transfer with the active-low hold input. The engine only advances on the qualified edge strobes produced here. When those strobes stop, its bit counter and shift data stay untouched, and the transfer picks up at the same bit once the pause ends.

A pause only begins or ends while the serial clock is low. If hold is pulled low while the clock is high, the pause is marked pending and takes effect at the next falling clock edge, and that edge is swallowed. If hold returns high before that edge, the pending pause is cancelled. Leaving a pause needs hold high and the clock low together. Independently of the clock, the serial output enable is removed as soon as hold is low. Chip select stays live throughout: deselecting during a pause clears the pause state.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset, with chip select inactive (`cs_n`=1), `frozen`, `pause_pend`, `sck_rise_q` and `sck_fall_q` are all 0.
- R2: With `cs_n`=0 and `sck`=0, driving `hold_n` low asserts `frozen` in the same cycle, with no further delay.
- R3: With `cs_n`=0 and `sck`=1, driving `hold_n` low raises `pause_pend` and leaves `frozen` at 0. At the next falling `sck`, `frozen` asserts, `pause_pend` drops and that falling edge gives no `sck_fall_q` pulse.
- R4: If `hold_n` returns high while `pause_pend` is 1, `pause_pend` drops in that cycle and the following falling `sck` passes as a `sck_fall_q` pulse.
- R5: `so_oe` is 0 whenever `hold_n` is 0, whatever the state of `sck` and `cs_n`. Otherwise `so_oe` follows `so_oe_in`.
- R6: While paused, `sck` transitions produce no `sck_rise_q` or `sck_fall_q` pulse. Raising `hold_n` while `sck` is 1 does not end the pause.
- R7: The pause ends on the clock cycle after one in which `hold_n`=1 and `sck`=0 are seen together. Later `sck` edges pass again.
- R8: When `cs_n` is high, the pause state is cleared: `frozen` is 0 from the next cycle on. Hold low while `cs_n` is high sets neither `frozen` nor `pause_pend`.
- R9: When not frozen, each rising `sck` transition gives a one-cycle `sck_rise_q` pulse. Each falling transition gives a one-cycle `sck_fall_q` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Synchronized chip select, active low |
| sck | input | 1 | Synchronized serial clock level |
| hold_n | input | 1 | Synchronized pause request, active low |
| so_oe_in | input | 1 | Output enable requested by the engine |
| sck_rise_q | output | 1 | Qualified rising-edge strobe to the engine |
| sck_fall_q | output | 1 | Qualified falling-edge strobe to the engine |
| frozen | output | 1 | Engine must ignore the bus this cycle |
| pause_pend | output | 1 | Pause requested, waiting for the clock to fall |
| so_oe | output | 1 | Serial output enable after the hold override |

## Verification
A falling serial clock edge and the start of a deferred pause land in the same cycle. The bench provokes this by lowering hold while the clock is high and then dropping the clock. It judges the result by `frozen` asserting in that same cycle while no fall strobe appears. A second overlap is a resume attempt and a clock edge together: hold is raised while the clock is high and the clock then falls. The fall must be swallowed and the pause must end one cycle later.

// File: rtl/spi_hold_gate.sv
module spi_hold_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  input  logic so_oe_in,
  output logic sck_rise_q,
  output logic sck_fall_q,
  output logic frozen,
  output logic pause_pend,
  output logic so_oe
);

  logic paused_q;
  logic sck_d;
  logic hold_req;
  logic resume_ok;

  assign hold_req   = ~cs_n & ~hold_n;
  assign resume_ok  = hold_n & ~sck;

  assign frozen     = paused_q | (hold_req & ~sck);
  assign pause_pend = ~paused_q & hold_req & sck;

  assign sck_rise_q = ~frozen & sck & ~sck_d;
  assign sck_fall_q = ~frozen & ~sck & sck_d;

  assign so_oe      = so_oe_in & hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused_q <= 1'b0;
      sck_d    <= 1'b0;
    end else begin
      sck_d <= sck;
      if (cs_n)
        paused_q <= 1'b0;
      else if (paused_q)
        paused_q <= ~resume_ok;
      else
        paused_q <= hold_req & ~sck;
    end
  end

endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic hold_n,
  input logic so_oe_in,
  input logic sck_rise_q,
  input logic sck_fall_q,
  input logic frozen,
  input logic pause_pend,
  input logic so_oe
);

  a_r5_so_released: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (hold_n && so_oe_in));

  a_r6_no_edge_when_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !(sck_rise_q || sck_fall_q));

  a_r6_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !cs_n && !(hold_n && !sck)) |=> frozen);

  a_r8_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!frozen || !cs_n));

  a_r3_pend_progress: assert property (@(posedge clk) disable iff (!rst_n)
    pause_pend |=> (frozen || pause_pend || hold_n || cs_n));

  a_r9_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise_q |-> sck);

  a_r9_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall_q |-> !sck);

endmodule

bind spi_hold_gate spi_hold_gate_chk u_chk (.*);

// File: tb/spi_hold_gate_bench.sv
`timescale 1ns/1ps
module spi_hold_gate_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic hold_n = 1'b1;
  logic so_oe_in = 1'b0;
  logic sck_rise_q, sck_fall_q, frozen, pause_pend, so_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_hold_gate u_spi_hold_gate (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .so_oe_in(so_oe_in), .sck_rise_q(sck_rise_q), .sck_fall_q(sck_fall_q),
    .frozen(frozen), .pause_pend(pause_pend), .so_oe(so_oe)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic s, input logic h);
    @(negedge clk);
    cs_n = c; sck = s; hold_n = h;
    #2;
  endtask

  task automatic t_reset;
    chk("R1", "frozen", frozen, 1'b0);
    chk("R1", "pause_pend", pause_pend, 1'b0);
    chk("R1", "rise", sck_rise_q, 1'b0);
    chk("R1", "fall", sck_fall_q, 1'b0);
  endtask

  task automatic t_edges;
    step(0, 0, 1);
    step(0, 1, 1); chk("R9", "rise pulse", sck_rise_q, 1'b1);
    step(0, 1, 1); chk("R9", "rise one cycle", sck_rise_q, 1'b0);
    step(0, 0, 1); chk("R9", "fall pulse", sck_fall_q, 1'b1);
    step(0, 0, 1); chk("R9", "fall one cycle", sck_fall_q, 1'b0);
  endtask

  task automatic t_immediate;
    step(0, 0, 0); chk("R2", "frozen at once", frozen, 1'b1);
    step(0, 1, 0); chk("R6", "rise swallowed", sck_rise_q, 1'b0);
    step(0, 0, 0); chk("R6", "fall swallowed", sck_fall_q, 1'b0);
    step(0, 0, 1); chk("R7", "frozen on resume cycle", frozen, 1'b1);
    step(0, 0, 1); chk("R7", "released next cycle", frozen, 1'b0);
    step(0, 1, 1); chk("R7", "rise passes after", sck_rise_q, 1'b1);
    step(0, 0, 1);
  endtask

  task automatic t_so;
    so_oe_in = 1'b1;
    step(0, 1, 0); chk("R5", "oe off hold low sck high", so_oe, 1'b0);
    step(0, 0, 0); chk("R5", "oe off hold low sck low", so_oe, 1'b0);
    step(1, 0, 0); chk("R5", "oe off hold low cs high", so_oe, 1'b0);
    step(0, 0, 1); chk("R5", "oe follows request", so_oe, 1'b1);
    so_oe_in = 1'b0; #1;
    chk("R5", "oe follows request low", so_oe, 1'b0);
    step(0, 0, 1); step(0, 0, 1);
  endtask

  task automatic t_deferred;
    step(0, 1, 1);
    step(0, 1, 0); chk("R3", "pending", pause_pend, 1'b1);
    chk("R3", "not yet frozen", frozen, 1'b0);
    step(0, 1, 0); chk("R3", "still pending", pause_pend, 1'b1);
    step(0, 0, 0); chk("R3", "frozen at fall", frozen, 1'b1);
    chk("R3", "fall swallowed", sck_fall_q, 1'b0);
    chk("R3", "pending cleared", pause_pend, 1'b0);
    step(0, 0, 1); step(0, 0, 1);
    chk("R7", "released", frozen, 1'b0);
  endtask

  task automatic t_cancel;
    step(0, 1, 1);
    step(0, 1, 0); chk("R4", "pending", pause_pend, 1'b1);
    step(0, 1, 1); chk("R4", "pending cancelled", pause_pend, 1'b0);
    step(0, 0, 1); chk("R4", "fall passes", sck_fall_q, 1'b1);
    chk("R4", "not frozen", frozen, 1'b0);
  endtask

  task automatic t_late_resume;
    step(0, 0, 0); chk("R2", "frozen", frozen, 1'b1);
    step(0, 1, 0); chk("R6", "rise swallowed", sck_rise_q, 1'b0);
    step(0, 1, 1); chk("R6", "hold up sck high still frozen", frozen, 1'b1);
    step(0, 1, 1); chk("R6", "still frozen", frozen, 1'b1);
    step(0, 0, 1); chk("R6", "fall swallowed on resume", sck_fall_q, 1'b0);
    chk("R7", "frozen during resume cycle", frozen, 1'b1);
    step(0, 0, 1); chk("R7", "released", frozen, 1'b0);
    step(0, 1, 1); chk("R7", "rise passes", sck_rise_q, 1'b1);
    step(0, 0, 1);
  endtask

  task automatic t_cs;
    step(0, 0, 0); chk("R2", "frozen", frozen, 1'b1);
    step(1, 0, 0);
    step(1, 0, 0); chk("R8", "cleared by deselect", frozen, 1'b0);
    step(1, 1, 0); chk("R8", "no pending when deselected", pause_pend, 1'b0);
    step(1, 0, 0); chk("R8", "no freeze when deselected", frozen, 1'b0);
    step(0, 0, 1); step(0, 0, 1);
    chk("R8", "reselected idle", frozen, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    t_reset;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #2;
    t_reset;
    t_edges;
    t_immediate;
    t_so;
    t_deferred;
    t_cancel;
    t_late_resume;
    t_cs;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule